// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and a 16-bit asynchronous static RAM. The host issues one access per request: a single-cycle pulse with a write flag, an address, write data and a two-bit byte mask. The controller then produces the memory strobes through a counted state sequence of idle, setup, strobe, hold and done. Each timed phase lasts a parameterised number of clock cycles, so the minimum nanosecond figures of the memory become cycle counts at the chosen clock.

Writes keep output enable high. They drive the data bus only while write enable is low and during the hold that follows. Reads open output enable for a counted window and sample the data bus and the memory's corrected-error flag at the last edge of that window, while the address is still held. The host sees a one-cycle done pulse. For a read, it then finds the data and the error flag latched.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset, `ready_o` is 1, `done_o` is 0, all active-low memory strobes (`mem_ce_no`, `mem_oe_no`, `mem_we_no`, `mem_ub_no`, `mem_lb_no`) are 1 and `mem_dq_oe_o` is 0.
- R2: A request is accepted only when `req_i` and `ready_o` are both 1, and the request fields are latched at that edge. `ready_o` then stays 0 until the controller is idle again. A request raised while `ready_o` is 0 is ignored: it causes no memory access and no extra done pulse.
- R3: `mem_addr_o` holds the accepted address and does not change while `mem_ce_no` is 0.
- R4: A write runs max(SETUP_CYC, TURN_CYC) cycles with chip enable low and write enable high. Write enable is then low for exactly WRITE_CYC cycles, followed by HOLD_CYC cycles with write enable high. `mem_oe_no` stays 1 throughout, and write enable is never low while chip enable is high.
- R5: `mem_dq_oe_o` is 1 only during the write-enable-low phase and the hold phase of a write, never while `mem_oe_no` is 0. It rises at least TURN_CYC cycles after `mem_oe_no` was last low. `mem_dq_o` is stable while it is driven.
- R6: Mask bit 1 selects the upper lane (bits 15:8, `mem_ub_no` low) and mask bit 0 selects the lower lane (bits 7:0, `mem_lb_no` low), for the whole access. A write changes only the selected lanes.
- R7: A read holds `mem_oe_no` low for READ_CYC cycles after the setup phase. It captures `mem_dq_i` and `mem_err_i` at the last edge of that window.
- R8: In `rdata_o`, the bytes of lanes not selected by the read mask are zero, whatever the memory presents.
- R9: `err_o` holds the error flag captured by the most recent read. Writes leave `rdata_o` and `err_o` unchanged.
- R10: `done_o` is a one-cycle pulse. It is high in the cycle that begins max(SETUP_CYC, TURN_CYC) + phase + HOLD_CYC + 1 edges after the accepting edge, where phase is WRITE_CYC for a write and READ_CYC for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request pulse |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | 2 | Byte mask, bit 1 upper lane, bit 0 lower lane |
| ready_o | output | 1 | Controller idle, request can be taken |
| done_o | output | 1 | Access finished, one cycle |
| rdata_o | output | DATA_W | Latched read data |
| err_o | output | 1 | Latched corrected-error flag of last read |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_ub_no | output | 1 | Upper byte enable, active low |
| mem_lb_no | output | 1 | Lower byte enable, active low |
| mem_dq_o | output | DATA_W | Data driven to memory |
| mem_dq_oe_o | output | 1 | Data bus driver enable |
| mem_dq_i | input | DATA_W | Data from memory |
| mem_err_i | input | 1 | Corrected-error flag from memory |

## Verification
A phase counter that is off by one shows up directly at the memory pins. The write-enable pulse comes out one cycle too short or too long, and the done pulse moves by a cycle on the very access where the count goes wrong. A wrong sample point or lane decode shows on the first read that follows. The read returns the bench model's idle pattern or its filler bytes instead of the stored word. A lost turnaround or hold shows within a cycle as bus drive overlapping output enable, or as drive released before write enable rises.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } state_e;
endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WRITE_CYC = 2,
  parameter int READ_CYC  = 2,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   we_i,
  output state_e state_o,
  output logic   accept_o,
  output logic   is_wr_o,
  output logic   sample_o
);
  // setup also covers bus turnaround before write drive
  localparam int SETUP_EFF = (SETUP_CYC > TURN_CYC) ? SETUP_CYC : TURN_CYC;
  localparam int MAX_A     = (SETUP_EFF > HOLD_CYC) ? SETUP_EFF : HOLD_CYC;
  localparam int MAX_B     = (WRITE_CYC > READ_CYC) ? WRITE_CYC : READ_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_EFF - 1);
  localparam logic [CNT_W-1:0] WRITE_LD = CNT_W'(WRITE_CYC - 1);
  localparam logic [CNT_W-1:0] READ_LD  = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  state_e           state_q, state_d;
  logic             is_wr_q;
  logic             ld, zero;
  logic [CNT_W-1:0] ld_val;

  assign accept_o = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = ST_SETUP;
        ld      = 1'b1;
        ld_val  = SETUP_LD;
      end
      ST_SETUP: if (zero) begin
        state_d = ST_STROBE;
        ld      = 1'b1;
        ld_val  = is_wr_q ? WRITE_LD : READ_LD;
      end
      ST_STROBE: if (zero) begin
        state_d = ST_HOLD;
        ld      = 1'b1;
        ld_val  = HOLD_LD;
      end
      ST_HOLD: if (zero) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) is_wr_q <= we_i;
    end
  end

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .zero_o     (zero)
  );

  assign state_o  = state_q;
  assign is_wr_o  = is_wr_q;
  assign sample_o = (state_q == ST_STROBE) && zero && !is_wr_q;
endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  state_e            state_i,
  input  logic              is_wr_i,
  input  logic              sample_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  input  logic              mem_err_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_ub_no,
  output logic              mem_lb_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  localparam int LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, lane_rd;
  logic [1:0]        be_q;
  logic              err_q;
  logic              active, strobe, drive_ph;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign lane_rd[i*LANE_W +: LANE_W] = be_q[i] ? mem_dq_i[i*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
      end
      if (sample_i) begin
        rdata_q <= lane_rd;
        err_q   <= mem_err_i;
      end
    end
  end

  assign active   = (state_i == ST_SETUP) || (state_i == ST_STROBE) || (state_i == ST_HOLD);
  assign strobe   = (state_i == ST_STROBE);
  assign drive_ph = strobe || (state_i == ST_HOLD);

  assign mem_addr_o  = addr_q;
  assign mem_ce_no   = !active;
  assign mem_ub_no   = !(active && be_q[1]);
  assign mem_lb_no   = !(active && be_q[0]);
  assign mem_oe_no   = !(strobe && !is_wr_i);
  assign mem_we_no   = !(strobe && is_wr_i);
  assign mem_dq_oe_o = drive_ph && is_wr_i;
  assign mem_dq_o    = wdata_q;
  assign rdata_o     = rdata_q;
  assign err_o       = err_q;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int SETUP_CYC = 1,
  parameter int WRITE_CYC = 2,
  parameter int READ_CYC  = 2,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_ub_no,
  output logic              mem_lb_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  input  logic              mem_err_i
);
  state_e state;
  logic   accept, is_wr, sample;

  sram_ctl_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .WRITE_CYC (WRITE_CYC),
    .READ_CYC  (READ_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .TURN_CYC  (TURN_CYC)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .state_o  (state),
    .accept_o (accept),
    .is_wr_o  (is_wr),
    .sample_o (sample)
  );

  sram_ctl_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .state_i     (state),
    .is_wr_i     (is_wr),
    .sample_i    (sample),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .be_i        (be_i),
    .mem_dq_i    (mem_dq_i),
    .mem_err_i   (mem_err_i),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_no   (mem_ce_no),
    .mem_oe_no   (mem_oe_no),
    .mem_we_no   (mem_we_no),
    .mem_ub_no   (mem_ub_no),
    .mem_lb_no   (mem_lb_no),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .rdata_o     (rdata_o),
    .err_o       (err_o)
  );

  assign ready_o = (state == ST_IDLE);
  assign done_o  = (state == ST_DONE);
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int WRITE_CYC = 2,
  parameter int TURN_CYC  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic              mem_ub_no,
  input logic              mem_lb_no,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  logic [7:0] we_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= '0;
    end else begin
      we_lo_cnt <= !mem_we_no ? ((we_lo_cnt == 8'hff) ? we_lo_cnt : we_lo_cnt + 1'b1) : '0;
      oe_hi_cnt <= mem_oe_no ? ((oe_hi_cnt == 8'hff) ? oe_hi_cnt : oe_hi_cnt + 1'b1) : '0;
    end
  end

  // R2
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);
  // R3
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));
  // R4
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_lo_cnt == 8'(WRITE_CYC)));
  // R4
  we_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_oe_no && !mem_ce_no));
  // R5
  drive_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);
  // R5
  turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (oe_hi_cnt >= 8'(TURN_CYC)));
  // R5
  dq_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));
  // R6
  lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ub_no || !mem_lb_no));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .WRITE_CYC (WRITE_CYC),
  .TURN_CYC  (TURN_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_no   (mem_ce_no),
  .mem_oe_no   (mem_oe_no),
  .mem_we_no   (mem_we_no),
  .mem_ub_no   (mem_ub_no),
  .mem_lb_no   (mem_lb_no),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
  localparam int AW = 20, DW = 16;
  localparam int S = 1, W = 2, RD = 2, H = 1, T = 1;
  localparam int SE = (S > T) ? S : T;
  localparam int LAT_WR = SE + W + H + 1;
  localparam int LAT_RD = SE + RD + H + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] be = 2'b11;
  logic ready, done, err;
  logic [DW-1:0] rdata;
  logic [AW-1:0] m_addr;
  logic ce_n, oe_n, we_n, ub_n, lb_n, dq_oe, m_err;
  logic [DW-1:0] dq_out, dq_in;

  logic [15:0] mem [16];
  logic        err_map [16];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .WRITE_CYC(W),
             .READ_CYC(RD), .HOLD_CYC(H), .TURN_CYC(T)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .err_o(err), .mem_addr_o(m_addr), .mem_ce_no(ce_n),
    .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_ub_no(ub_n), .mem_lb_no(lb_n),
    .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in), .mem_err_i(m_err));

  // memory model: filler on unselected lanes, idle pattern when not reading
  always_comb begin
    if (!ce_n && !oe_n) begin
      dq_in = {ub_n ? 8'hA5 : mem[m_addr[3:0]][15:8], lb_n ? 8'h5A : mem[m_addr[3:0]][7:0]};
      m_err = err_map[m_addr[3:0]];
    end else begin
      dq_in = 16'hDEAD;
      m_err = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req_s, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req_s, what, act, exp);
    end
  endtask

  // protocol monitor, write commit on write-enable rise
  int we_lo = 0, oe_hi = 0;
  logic dq_prev = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (dq_oe && !dq_prev) check(oe_hi >= T, "R5", "turnaround cycles", oe_hi, T);
    if (dq_oe && !oe_n) check(1'b0, "R5", "drive with oe low", 1, 0);
    if (!we_n) we_lo++;
    else if (we_lo != 0) begin
      check(we_lo == W, "R4", "we low width", we_lo, W);
      check(dq_oe && oe_n && !ce_n, "R4", "hold drive/oe/ce", {dq_oe, oe_n, ce_n}, 3'b110);
      if (!ub_n) mem[m_addr[3:0]][15:8] = dq_out[15:8];
      if (!lb_n) mem[m_addr[3:0]][7:0]  = dq_out[7:0];
      we_lo = 0;
    end
    oe_hi   = oe_n ? oe_hi + 1 : 0;
    dq_prev = dq_oe;
  end

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] m, output int lat);
    @(negedge clk);
    check(ready, "R2", "ready before request", ready, 1);
    req = 1'b1; we = wr; addr = a; wdata = d; be = m;
    @(negedge clk);
    req = 1'b0; addr = '1; wdata = '1; be = 2'b00;
    lat = 1;
    check(!ready, "R2", "ready low when busy", ready, 0);
    @(negedge clk); lat++;
    check(m_addr == a, "R3", "address held", m_addr, a);
    check({ub_n, lb_n} == ~m, "R6", "lane strobes", {ub_n, lb_n}, ~m);
    while (!done && lat < 40) begin @(negedge clk); lat++; end
  endtask

  task automatic t_reset();
    check(ready && !done, "R1", "ready/done", {ready, done}, 2'b10);
    check({ce_n, oe_n, we_n, ub_n, lb_n} == 5'h1f, "R1", "strobes idle",
          {ce_n, oe_n, we_n, ub_n, lb_n}, 5'h1f);
    check(!dq_oe, "R1", "bus drive", dq_oe, 0);
  endtask

  task automatic t_write_read();
    int lat;
    access(1'b1, 20'h00003, 16'h1234, 2'b11, lat);
    check(lat == LAT_WR, "R10", "write latency", lat, LAT_WR);
    @(negedge clk);
    check(!done, "R10", "done one cycle", done, 0);
    check(mem[3] == 16'h1234, "R4", "word written", mem[3], 16'h1234);
    access(1'b0, 20'h00003, 16'h0, 2'b11, lat);
    check(lat == LAT_RD, "R10", "read latency", lat, LAT_RD);
    check(rdata == 16'h1234, "R7", "read data", rdata, 16'h1234);
    check(!err, "R9", "no error", err, 0);
    @(negedge clk);
  endtask

  task automatic t_byte_lanes();
    int lat;
    access(1'b1, 20'h00003, 16'hABCD, 2'b01, lat);
    @(negedge clk);
    check(mem[3] == 16'h12CD, "R6", "lower-only write", mem[3], 16'h12CD);
    access(1'b1, 20'h00003, 16'hEF99, 2'b10, lat);
    @(negedge clk);
    check(mem[3] == 16'hEFCD, "R6", "upper-only write", mem[3], 16'hEFCD);
    access(1'b0, 20'h00003, 16'h0, 2'b10, lat);
    check(rdata == 16'hEF00, "R8", "upper-only read", rdata, 16'hEF00);
    @(negedge clk);
    access(1'b0, 20'h00003, 16'h0, 2'b01, lat);
    check(rdata == 16'h00CD, "R8", "lower-only read", rdata, 16'h00CD);
    @(negedge clk);
  endtask

  task automatic t_error_flag();
    int lat;
    access(1'b1, 20'h00005, 16'h5555, 2'b11, lat);
    @(negedge clk);
    err_map[5] = 1'b1;
    access(1'b0, 20'h00005, 16'h0, 2'b11, lat);
    check(err, "R9", "error latched", err, 1);
    check(rdata == 16'h5555, "R7", "data with error", rdata, 16'h5555);
    @(negedge clk);
    access(1'b1, 20'h00006, 16'h6666, 2'b11, lat);
    check(err && rdata == 16'h5555, "R9", "write keeps rdata/err",
          {err, rdata}, {1'b1, 16'h5555});
    @(negedge clk);
    access(1'b0, 20'h00006, 16'h0, 2'b11, lat);
    check(!err && rdata == 16'h6666, "R9", "next read clears error",
          {err, rdata}, {1'b0, 16'h6666});
    @(negedge clk);
  endtask

  task automatic t_busy_refuse();
    int lat, extra;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 20'h00007; wdata = 16'h7777; be = 2'b11;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 20'h00008; wdata = 16'h8888; be = 2'b11;
    check(!ready, "R2", "busy refuses", ready, 0);
    @(negedge clk);
    req = 1'b0;
    lat = 3;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    check(lat == LAT_WR, "R10", "latency under busy req", lat, LAT_WR);
    extra = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (done) extra++; end
    check(extra == 0, "R2", "no extra done", extra, 0);
    check(mem[8] == 16'h0 && mem[7] == 16'h7777, "R2", "refused write absent",
          {mem[8], mem[7]}, {16'h0, 16'h7777});
  endtask

  task automatic t_turnaround();
    int lat;
    access(1'b0, 20'h00007, 16'h0, 2'b11, lat);
    check(rdata == 16'h7777, "R7", "read before write", rdata, 16'h7777);
    access(1'b1, 20'h00009, 16'h9A9A, 2'b11, lat);
    @(negedge clk);
    check(mem[9] == 16'h9A9A, "R5", "write after read", mem[9], 16'h9A9A);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = '0; err_map[i] = 1'b0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_byte_lanes();
    t_error_flag();
    t_busy_refuse();
    t_turnaround();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule